// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Seconds Shadow

This block keeps wall-clock time as two counters driven by a one-cycle 1 kHz tick pulse: a millisecond count that runs from 0 to 999 and a 32-bit seconds count that wraps. The tick is an input, so it keeps advancing whenever the tick source keeps pulsing, including in low-power states where the rest of the chip is idle. The block has no internal notion of power state.

Reading a multi-word time can tear. If the milliseconds are read just before a rollover and the seconds just after, the combined value is wrong. To avoid this, a read of the millisecond register copies the live seconds into a shadow register on the same clock edge that samples the milliseconds. Software therefore reads milliseconds first and shadow seconds second, then forms seconds*1000 + milliseconds as a 32-bit wrapping count. Software sets the time by writing the seconds register.

The register port uses plain strobes. Reads are registered: data comes back one cycle after the strobe, marked by a one-cycle valid pulse. There is no back-pressure, so a read strobe is accepted in every cycle.

Top module: `shadow_rtc`

## Requirements
- R1: After reset the seconds, millisecond and shadow registers are 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: Each cycle with `tick_1k` high advances the millisecond count by one. Without a tick or a seconds write, milliseconds and seconds keep their values.
- R3: A tick while milliseconds equal 999 sets milliseconds to 0 and increments seconds on the same edge. Seconds wrap from 0xFFFFFFFF to 0.
- R4: A read at byte offset 0x10 returns the millisecond count, zero-extended. On that same edge the current seconds value is copied into the shadow register.
- R5: A read at offset 0x0C returns the shadow register. The shadow register changes only on a millisecond read; ticks, writes and other reads leave it unchanged.
- R6: A read at offset 0x08 returns the live seconds count.
- R7: A write at offset 0x08 loads seconds from `wr_data` and clears milliseconds to 0. If a tick arrives in the same cycle, the write wins.
- R8: Writes to any other offset, including 0x0C and 0x10, have no effect.
- R9: `rd_valid` is high exactly one cycle after each cycle with `rd_en` high. `rd_data` carries the result in that cycle. Reads of offsets other than 0x08, 0x0C and 0x10 return 0.
- R10: When a millisecond read and a tick occur in the same cycle, the read returns the pre-tick milliseconds and the shadow captures the pre-tick seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz |
| reg_addr | input | 8 | Byte offset of the register access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |

## Verification
The counters are driven with tick bursts of different lengths: short bursts stay inside a second, bursts that end exactly at 999 reach the limit, and a single tick past 999 separates a correct carry from an off-by-one limit. The shadow register is checked with a millisecond read followed by a seconds rollover. This pattern tells a true snapshot apart from a live copy, because the shadow must still hold the old second while the live register shows the new one. Same-cycle collisions, a read with a tick and a write with a tick, expose wrong edge ordering or wrong priority. Writes to the read-only offsets and reads of unmapped offsets confirm that address decoding touches nothing else.

// File: rtl/shadow_rtc_pkg.sv
package shadow_rtc_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_SEC    = 2'd1,
    SEL_SHADOW = 2'd2,
    SEL_MS     = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import shadow_rtc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OFS_SEC    = 8'h08,
  parameter int OFS_SHADOW = 8'h0C,
  parameter int OFS_MS     = 8'h10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFS_SEC))         sel = SEL_SEC;
    else if (addr == ADDR_W'(OFS_SHADOW)) sel = SEL_SHADOW;
    else if (addr == ADDR_W'(OFS_MS))     sel = SEL_MS;
    else                                  sel = SEL_NONE;
  end

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
  parameter int SEC_W      = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = $clog2(MS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  output logic [SEC_W-1:0] sec,
  output logic [MS_W-1:0]  ms
);

  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic ms_at_last;
  assign ms_at_last = (ms == MS_LAST);

  // A seconds load takes priority over the tick.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0;
      ms  <= '0;
    end else if (load) begin
      sec <= load_sec;
      ms  <= '0;
    end else if (tick) begin
      if (ms_at_last) begin
        ms  <= '0;
        sec <= sec + SEC_W'(1);
      end else begin
        ms  <= ms + MS_W'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_shadow_capture.sv
module rtc_shadow_capture #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [SEC_W-1:0] live_sec,
  output logic [SEC_W-1:0] shadow_sec
);

  always_ff @(posedge clk) begin
    if (!rst_n)       shadow_sec <= '0;
    else if (capture) shadow_sec <= live_sec;
  end

endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import shadow_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [SEC_W-1:0]  sec,
  input  logic [SEC_W-1:0]  shadow_sec,
  input  logic [MS_W-1:0]   ms,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] mux_val;

  always_comb begin
    unique case (sel)
      SEL_SEC:    mux_val = DATA_W'(sec);
      SEL_SHADOW: mux_val = DATA_W'(shadow_sec);
      SEL_MS:     mux_val = DATA_W'(ms);
      default:    mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux_val;
    end
  end

endmodule

// File: rtl/shadow_rtc.sv
module shadow_rtc
  import shadow_rtc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int OFS_SEC    = 8'h08,
  parameter int OFS_SHADOW = 8'h0C,
  parameter int OFS_MS     = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1k,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int SEC_W = DATA_W;
  localparam int MS_W  = $clog2(MS_PER_SEC);

  reg_sel_e         sel;
  logic [SEC_W-1:0] sec_cnt;
  logic [SEC_W-1:0] shadow_sec;
  logic [MS_W-1:0]  ms_cnt;
  logic             sec_load;
  logic             ms_read;

  rtc_addr_decode #(
    .ADDR_W(ADDR_W), .OFS_SEC(OFS_SEC), .OFS_SHADOW(OFS_SHADOW), .OFS_MS(OFS_MS)
  ) u_dec (
    .addr(reg_addr),
    .sel (sel)
  );

  assign sec_load = wr_en && (sel == SEL_SEC);
  assign ms_read  = rd_en && (sel == SEL_MS);

  rtc_time_counter #(
    .SEC_W(SEC_W), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1k),
    .load    (sec_load),
    .load_sec(wr_data),
    .sec     (sec_cnt),
    .ms      (ms_cnt)
  );

  rtc_shadow_capture #(.SEC_W(SEC_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (ms_read),
    .live_sec  (sec_cnt),
    .shadow_sec(shadow_sec)
  );

  rtc_read_port #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .sel       (sel),
    .sec       (sec_cnt),
    .shadow_sec(shadow_sec),
    .ms        (ms_cnt),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/shadow_rtc_chk.sv
module shadow_rtc_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = 10,
  parameter int OFS_SEC    = 8'h08,
  parameter int OFS_MS     = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1k,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] sec,
  input logic [DATA_W-1:0] shadow,
  input logic [MS_W-1:0]   ms
);

  logic is_sec_wr, is_ms_rd;
  assign is_sec_wr = wr_en && (reg_addr == ADDR_W'(OFS_SEC));
  assign is_ms_rd  = rd_en && (reg_addr == ADDR_W'(OFS_MS));

  // R2
  ms_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms < MS_W'(MS_PER_SEC));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1k && !is_sec_wr) |=> ($stable(ms) && $stable(sec)));

  // R3
  rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1k && !is_sec_wr && ms == MS_W'(MS_PER_SEC - 1))
      |=> (ms == '0 && sec == $past(sec) + DATA_W'(1)));

  // R4
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ms_rd |=> (shadow == $past(sec)));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ms_rd |=> $stable(shadow));

  // R7
  sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_sec_wr |=> (sec == $past(wr_data) && ms == '0));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

endmodule

bind shadow_rtc shadow_rtc_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MS_PER_SEC(MS_PER_SEC),
  .MS_W($clog2(MS_PER_SEC)), .OFS_SEC(OFS_SEC), .OFS_MS(OFS_MS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_1k (tick_1k),
  .reg_addr(reg_addr),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_valid(rd_valid),
  .sec     (sec_cnt),
  .shadow  (shadow_sec),
  .ms      (ms_cnt)
);

// File: tb/shadow_rtc_tb_top.sv
module shadow_rtc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1k = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shadow_rtc dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .reg_addr(reg_addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  localparam logic [7:0] A_SEC = 8'h08, A_SHD = 8'h0C, A_MS = 8'h10;
  localparam logic [1:0] K_TICK = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{K_WR,   A_SEC, 32'd5,   32'd0,   8'd7},
    '{K_TICK, 8'h00, 32'd3,   32'd0,   8'd2},
    '{K_RD,   A_MS,  32'd0,   32'd3,   8'd2},   // R2
    '{K_RD,   A_SHD, 32'd0,   32'd5,   8'd4},   // R4
    '{K_TICK, 8'h00, 32'd996, 32'd0,   8'd2},
    '{K_RD,   A_MS,  32'd0,   32'd999, 8'd2},
    '{K_TICK, 8'h00, 32'd1,   32'd0,   8'd3},
    '{K_RD,   A_MS,  32'd0,   32'd0,   8'd3},   // R3
    '{K_RD,   A_SHD, 32'd0,   32'd6,   8'd4},
    '{K_RD,   A_SEC, 32'd0,   32'd6,   8'd6},   // R6
    '{K_TICK, 8'h00, 32'd999, 32'd0,   8'd2},
    '{K_RD,   A_MS,  32'd0,   32'd999, 8'd4},
    '{K_TICK, 8'h00, 32'd1,   32'd0,   8'd3},
    '{K_RD,   A_SHD, 32'd0,   32'd6,   8'd5},   // R5 snapshot keeps old second
    '{K_RD,   A_SEC, 32'd0,   32'd7,   8'd6},
    '{K_TICK, 8'h00, 32'd4,   32'd0,   8'd2},
    '{K_WR,   A_MS,  32'd77,  32'd0,   8'd8},
    '{K_RD,   A_MS,  32'd0,   32'd4,   8'd8},   // R8
    '{K_WR,   A_SHD, 32'd123, 32'd0,   8'd8},
    '{K_RD,   A_SHD, 32'd0,   32'd7,   8'd8},
    '{K_RD,   8'h00, 32'd0,   32'd0,   8'd9},   // R9 unmapped
    '{K_RD,   8'h14, 32'd0,   32'd0,   8'd9}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  task automatic do_read(input logic [7:0] a, input string req, input logic [31:0] expv);
    @(negedge clk);
    reg_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check({req, " valid"}, {31'd0, rd_valid}, 32'd1);
    check(req, rd_data, expv);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1k = 1'b1;
      @(negedge clk); tick_1k = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    do_read(A_SEC, "R1 sec", 32'd0);
    do_read(A_SHD, "R1 shadow", 32'd0);
    do_read(A_MS, "R1 ms", 32'd0);

    for (int v = 0; v < NV; v++) begin
      case (VECS[v].kind)
        K_TICK:  do_ticks(int'(VECS[v].data));
        K_WR:    do_write(VECS[v].addr, VECS[v].data);
        default: do_read(VECS[v].addr, $sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].expv);
      endcase
    end

    // R9 idle cycle: no valid without a strobe
    @(negedge clk);
    check("R9 no strobe", {31'd0, rd_valid}, 32'd0);

    // R3 wrap of seconds, R10 read colliding with tick
    do_write(A_SEC, 32'hFFFF_FFFF);
    do_ticks(999);
    @(negedge clk);
    reg_addr = A_MS; rd_en = 1'b1; tick_1k = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; tick_1k = 1'b0;
    check("R10 ms pre-tick", rd_data, 32'd999);
    do_read(A_SHD, "R10 shadow pre-tick", 32'hFFFF_FFFF);
    do_read(A_SEC, "R3 seconds wrap", 32'd0);
    do_read(A_MS, "R3 ms after wrap", 32'd0);

    // R7 write beats tick
    do_ticks(5);
    @(negedge clk);
    reg_addr = A_SEC; wr_data = 32'd40; wr_en = 1'b1; tick_1k = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1k = 1'b0;
    do_read(A_MS, "R7 ms cleared", 32'd0);
    do_read(A_SEC, "R7 sec loaded", 32'd40);
    do_read(A_SHD, "R5 shadow from last ms read", 32'd40);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule